// File: doc/BRIEF.md
# Register-Paced Serial Pin Controller

This peripheral lets a host processor operate a serial peripheral bus by hand. Four word registers sit behind a simple 32-bit write/read port. The first is a mode word. The second is a general-purpose control word that has no effect on the pins. The third is a pin word whose fields drive the serial clock, the data-out line and three active-low chip selects. The fourth is a capture register that collects the serial data coming back. While the mode bit is clear, the pins are passed through unchanged from an external transfer engine. While it is set, the pins follow the pin word.

Software moves one bit with two writes to the pin word. The first write sets up the data bit with the clock low. The second write repeats the same value with the clock high. Each write that raises the stored clock bit from 0 to 1 in direct mode shifts the synchronized data-in line into bit 0 of a 32-bit capture register, and everything already captured moves one place up. After eight such pulses, sent most significant bit first, the low byte of the capture register holds the received byte. The host can read the capture register at any time.

Top module: `spi_pin_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the mode word reads 0, the control word reads 0, the pin word reads 0x0007_0000 and the capture register reads 0. On the first entry into direct mode the clock and data-out pins are low and all chip selects are high.
- R2: Bit 0 of the mode word (byte offset 0x00) selects direct pin control when 1. Only that bit is stored, and the other bits read as 0.
- R3: In direct mode the pin word (offset 0x08) drives data-out from bit 0, the clock from bit 8 and chip select n from bit 16+n (n = 0..2). The pins change in the cycle after the write. The pin word reads back all 32 bits as written.
- R4: With the mode bit clear, the clock, data-out and chip-select pins follow the engine inputs combinationally. Pin-word writes are still stored and read back.
- R5: A pin-word write in direct mode that sets bit 8 while the stored bit 8 is 0 shifts data-in into bit 0 of the capture register. A write that keeps bit 8 at 1, a write with bit 8 at 0, and any write in engine mode leave the capture register unchanged.
- R6: After eight clock pulses, the capture register (offset 0x0C) holds the eight received bits in its low byte, with the first bit received in bit 7. Its upper bits hold the earlier bits, oldest highest.
- R7: The control word (offset 0x04) stores all 32 written bits and reads them back.
- R8: Writes to the capture offset, and writes to byte addresses that are not word-aligned, change no register. Reads of misaligned addresses return 0.
- R9: A read of the capture register in the same cycle as a clock-raising write returns the value before the shift. The shifted value is visible from the next cycle.
- R10: Data-in passes through a 2-stage synchronizer. The captured bit is the data-in level held for at least two cycles before the clock-raising write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read byte address |
| rd_data | output | 32 | Read data (combinational) |
| eng_sclk | input | 1 | Clock from the transfer engine |
| eng_mosi | input | 1 | Data-out from the transfer engine |
| eng_csn | input | 3 | Active-low chip selects from the transfer engine |
| miso | input | 1 | Serial data-in pin |
| sclk | output | 1 | Serial clock pin |
| mosi | output | 1 | Serial data-out pin |
| csn | output | 3 | Active-low chip select pins |

## Verification
Two functions can fall in the same cycle: a host read of the capture register, and the shift caused by a clock-raising write to the pin word. The bench provokes this by holding the read address on the capture offset while it presents the clock-raising write. It samples the read data just before the capturing edge and expects the pre-shift value. It samples again one cycle later and expects the value with the new bit appended. The bench also sweeps all 256 receive bytes through the capture path, each against a bench model of the 32-bit history.

// File: rtl/spi_pin_pkg.sv
package spi_pin_pkg;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 32;
  localparam int WIDX_LO = 2;

  typedef enum logic [1:0] {
    WSEL_MODE  = 2'd0,
    WSEL_CTRL  = 2'd1,
    WSEL_PINS  = 2'd2,
    WSEL_CAPT  = 2'd3
  } word_sel_e;

  localparam int BIT_MODE = 0;
  localparam int BIT_DOUT = 0;
  localparam int BIT_SCLK = 8;
  localparam int BIT_CS0  = 16;
endpackage

// File: rtl/spi_pin_regs.sv
module spi_pin_regs
  import spi_pin_pkg::*;
#(
  parameter int NUM_CS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              mode_o,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] pins_o,
  output logic              sclk_rise_o
);
  localparam logic [DATA_W-1:0] CS_ONES  = DATA_W'((64'd1 << NUM_CS) - 64'd1);
  localparam logic [DATA_W-1:0] PINS_RST = CS_ONES << BIT_CS0;

  logic              mode_q, mode_d, mode_en;
  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] pins_q, pins_d;
  logic              ctrl_en, pins_en;
  logic              aligned;
  word_sel_e         sel;

  always_comb begin
    aligned = (wr_addr[WIDX_LO-1:0] == '0);
    sel     = word_sel_e'(wr_addr[ADDR_W-1:WIDX_LO]);
    mode_en = wr_en && aligned && (sel == WSEL_MODE);
    ctrl_en = wr_en && aligned && (sel == WSEL_CTRL);
    pins_en = wr_en && aligned && (sel == WSEL_PINS);
    mode_d  = mode_en ? wr_data[BIT_MODE] : mode_q;
    ctrl_d  = ctrl_en ? wr_data : ctrl_q;
    pins_d  = pins_en ? wr_data : pins_q;
    sclk_rise_o = pins_en && mode_q && wr_data[BIT_SCLK] && !pins_q[BIT_SCLK];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      ctrl_q <= '0;
      pins_q <= PINS_RST;
    end else begin
      mode_q <= mode_d;
      ctrl_q <= ctrl_d;
      pins_q <= pins_d;
    end
  end

  assign mode_o = mode_q;
  assign ctrl_o = ctrl_q;
  assign pins_o = pins_q;

  // R7: the control word only moves on its own write
  assert_ctrl_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == 4'h4) |=> $stable(ctrl_o));
  assert_ctrl_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 4'h4) |=> ctrl_o == $past(wr_data));
  // R2: mode follows bit 0 of its write
  assert_mode_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 4'h0) |=> mode_o == $past(wr_data[0]));
endmodule

// File: rtl/spi_pin_capture.sv
module spi_pin_capture #(
  parameter int SHIFT_W     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               miso_i,
  input  logic               shift_en_i,
  output logic [SHIFT_W-1:0] shift_o
);
  logic               din_s;
  logic [SHIFT_W-1:0] shift_q, shift_d;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign din_s = miso_i;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], miso_i};
      end
      assign din_s = sync_q[SYNC_STAGES-1];
    end
  endgenerate

  always_comb begin
    shift_d = shift_en_i ? {shift_q[SHIFT_W-2:0], din_s} : shift_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign shift_o = shift_q;

  // R5: a clock rise appends the synchronized bit
  assert_capture_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en_i |=> shift_o == {$past(shift_o[SHIFT_W-2:0]), $past(din_s)});
  // R5: no rise, no movement
  assert_capture_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en_i |=> $stable(shift_o));
endmodule

// File: rtl/spi_pin_mux.sv
module spi_pin_mux
  import spi_pin_pkg::*;
#(
  parameter int NUM_CS = 3
) (
  input  logic              mode_i,
  input  logic [DATA_W-1:0] pins_i,
  input  logic              eng_sclk_i,
  input  logic              eng_mosi_i,
  input  logic [NUM_CS-1:0] eng_csn_i,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic [NUM_CS-1:0] csn_o
);
  assign sclk_o = mode_i ? pins_i[BIT_SCLK] : eng_sclk_i;
  assign mosi_o = mode_i ? pins_i[BIT_DOUT] : eng_mosi_i;

  generate
    for (genvar n = 0; n < NUM_CS; n++) begin : g_cs
      assign csn_o[n] = mode_i ? pins_i[BIT_CS0+n] : eng_csn_i[n];
    end
  endgenerate
endmodule

// File: rtl/spi_pin_ctrl.sv
module spi_pin_ctrl
  import spi_pin_pkg::*;
#(
  parameter int NUM_CS      = 3,
  parameter int SHIFT_W     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              eng_sclk,
  input  logic              eng_mosi,
  input  logic [NUM_CS-1:0] eng_csn,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic [NUM_CS-1:0] csn
);
  logic               mode;
  logic [DATA_W-1:0]  ctrl_w, pins_w;
  logic               sclk_rise;
  logic [SHIFT_W-1:0] capt;
  word_sel_e          rsel;

  spi_pin_regs #(.NUM_CS(NUM_CS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mode_o(mode), .ctrl_o(ctrl_w), .pins_o(pins_w),
    .sclk_rise_o(sclk_rise)
  );

  spi_pin_capture #(.SHIFT_W(SHIFT_W), .SYNC_STAGES(SYNC_STAGES)) u_capt (
    .clk(clk), .rst_n(rst_n), .miso_i(miso), .shift_en_i(sclk_rise),
    .shift_o(capt)
  );

  spi_pin_mux #(.NUM_CS(NUM_CS)) u_mux (
    .mode_i(mode), .pins_i(pins_w), .eng_sclk_i(eng_sclk),
    .eng_mosi_i(eng_mosi), .eng_csn_i(eng_csn), .sclk_o(sclk),
    .mosi_o(mosi), .csn_o(csn)
  );

  always_comb begin
    rsel    = word_sel_e'(rd_addr[ADDR_W-1:WIDX_LO]);
    rd_data = '0;
    if (rd_addr[WIDX_LO-1:0] == '0) begin
      case (rsel)
        WSEL_MODE: rd_data[BIT_MODE] = mode;
        WSEL_CTRL: rd_data = ctrl_w;
        WSEL_PINS: rd_data = pins_w;
        WSEL_CAPT: rd_data = DATA_W'(capt);
        default:   rd_data = '0;
      endcase
    end
  end

  // R8: a write aimed at the capture offset leaves it untouched
  assert_capt_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 4'hC) |=> $stable(capt));
  // R3: in steady direct mode the clock pin follows the last pin-word write
  assert_sclk_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && wr_en && wr_addr == 4'h8) ##1 mode |-> sclk == $past(wr_data[8]));
endmodule

// File: tb/tb_spi_pin_ctrl.sv
module tb_spi_pin_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic        eng_sclk, eng_mosi, miso;
  logic [2:0]  eng_csn;
  logic        sclk, mosi;
  logic [2:0]  csn;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_cap;
  logic [31:0] v;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_pin_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .eng_sclk(eng_sclk), .eng_mosi(eng_mosi), .eng_csn(eng_csn),
    .miso(miso), .sclk(sclk), .mosi(mosi), .csn(csn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at a falling edge with one idle cycle after the write
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    eng_sclk = 1'b1; eng_mosi = 1'b0; eng_csn = 3'b101; miso = 1'b0;
    exp_cap = '0;
    repeat (3) @(negedge clk);
    rd(4'h8, v); chk("R1 pin word during reset", v, 32'h0007_0000);
    rst_n = 1'b1;
    @(negedge clk);
    rd(4'h0, v); chk("R1 mode", v, 0);
    rd(4'h4, v); chk("R1 ctrl", v, 0);
    rd(4'h8, v); chk("R1 pin word", v, 32'h0007_0000);
    rd(4'hC, v); chk("R1 capture", v, 0);
    chk("R4 engine pins at reset", {27'd0, sclk, mosi, csn}, {27'd0, 1'b1, 1'b0, 3'b101});

    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, v); chk("R2 mode reads only bit 0", v, 1);
    chk("R1 direct pins after reset", {27'd0, sclk, mosi, csn}, {27'd0, 1'b0, 1'b0, 3'b111});

    wr(4'h4, 32'hA5C3_1E0F);
    rd(4'h4, v); chk("R7 ctrl readback", v, 32'hA5C3_1E0F);
    wr(4'h4, 32'h5A3C_E1F0);
    rd(4'h4, v); chk("R7 ctrl readback 2", v, 32'h5A3C_E1F0);

    // R3: every data-out / chip-select combination with the clock held low
    for (int k = 0; k < 16; k++) begin
      logic [31:0] p;
      p = 32'hAA00_AA00 | (32'(k[3:1]) << 16) | 32'(k[0]);
      wr(4'h8, p);
      rd(4'h8, v); chk("R3 pin word readback", v, p);
      chk("R3 pins", {27'd0, sclk, mosi, csn}, {27'd0, 1'b0, k[0], k[3:1]});
    end
    rd(4'hC, v); chk("R5 no shift with clock low", v, 0);

    // R6/R10: every receive byte, sent MSB first, data-out carries its complement
    for (int b = 0; b < 256; b++) begin
      for (int i = 7; i >= 0; i--) begin
        logic tb_bit, rx_bit;
        rx_bit = b[i];
        tb_bit = ~rx_bit;
        miso = rx_bit;
        wr(4'h8, 32'h0006_0000 | 32'(tb_bit));
        chk("R3 data-out setup", {30'd0, sclk, mosi}, {30'd0, 1'b0, tb_bit});
        wr(4'h8, 32'h0006_0100 | 32'(tb_bit));
        chk("R3 clock high", {27'd0, sclk, mosi, csn}, {27'd0, 1'b1, tb_bit, 3'b110});
        exp_cap = {exp_cap[30:0], rx_bit};
      end
      rd(4'hC, v);
      chk("R6 capture history", v, exp_cap);
      chk("R6 received byte", {24'd0, v[7:0]}, 32'(b));
    end

    // R5: rewriting with the clock already high does not shift
    miso = 1'b1;
    wr(4'h8, 32'h0006_0100);
    rd(4'hC, v); chk("R5 no shift on 1 to 1", v, exp_cap);

    // R9: read during the capturing write sees the old value
    wr(4'h8, 32'h0006_0000);
    rd_addr = 4'hC;
    wr_en = 1'b1; wr_addr = 4'h8; wr_data = 32'h0006_0100;
    #1;
    chk("R9 read in capture cycle", rd_data, exp_cap);
    @(negedge clk);
    wr_en = 1'b0;
    exp_cap = {exp_cap[30:0], 1'b1};
    #1;
    chk("R9 read after capture", rd_data, exp_cap);
    @(negedge clk);

    // R10: a data-in change one cycle before the rise is not yet seen
    wr(4'h8, 32'h0006_0000);
    miso = 1'b1;
    @(negedge clk);
    miso = 1'b0;
    wr_en = 1'b1; wr_addr = 4'h8; wr_data = 32'h0006_0100;
    @(negedge clk);
    wr_en = 1'b0;
    exp_cap = {exp_cap[30:0], 1'b1};
    @(negedge clk);
    rd(4'hC, v); chk("R10 two-stage synchronizer", v, exp_cap);

    // R8: capture offset and misaligned writes ignored
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'hC, v); chk("R8 capture write ignored", v, exp_cap);
    wr(4'h5, 32'h1234_5678);
    rd(4'h4, v); chk("R8 misaligned write ignored", v, 32'h5A3C_E1F0);
    rd(4'h6, v); chk("R8 misaligned read zero", v, 0);

    // R4/R5: engine mode
    wr(4'h0, 32'h0);
    eng_sclk = 1'b0; eng_mosi = 1'b1; eng_csn = 3'b011;
    #1;
    chk("R4 engine pass-through", {27'd0, sclk, mosi, csn}, {27'd0, 1'b0, 1'b1, 3'b011});
    eng_sclk = 1'b1; eng_csn = 3'b100;
    #1;
    chk("R4 engine pass-through 2", {27'd0, sclk, mosi, csn}, {27'd0, 1'b1, 1'b1, 3'b100});
    @(negedge clk);
    miso = 1'b1;
    wr(4'h8, 32'h0001_0000);
    wr(4'h8, 32'h0001_0101);
    rd(4'h8, v); chk("R4 pin word stored in engine mode", v, 32'h0001_0101);
    chk("R4 pins ignore pin word", {27'd0, sclk, mosi, csn}, {27'd0, 1'b1, 1'b1, 3'b100});
    rd(4'hC, v); chk("R5 no shift in engine mode", v, exp_cap);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule